// File: doc/BRIEF.md
# TDM Time-Slot Interchange Core

This block moves 8-bit channels between sixteen parallel input streams and sixteen output streams without blocking. The serial stages around it present, on each clock where `slot_en` is high, one byte per input stream for the channel named by `cur_ch`. In the same step the block registers one byte and one drive-enable per output stream for that same channel index. The block owns the frame count. The number of channels in a frame is set by a rate code.

Received bytes go into a two-bank data store. For each output stream and channel slot, a connection word chooses one of three things: a source stream and channel, a fixed message byte, or an undriven slot. A normal connection can take the constant-delay path, which reads only the bank filled in the previous frame. It can instead take the low-latency path, which reads the bank being filled when the source channel has already arrived in this frame. A host reaches the connection words and one control register through a 16-bit register port.

Top module: `tsi_core`

## Requirements
- R1: `cur_ch` starts at 0 after reset and advances by one on each clock with `slot_en` high. It wraps to 0 after channel L-1, where L = MAXCH >> (3 - rate), with the rate code reset to 0.
- R2: On a clock with `slot_en` high, `out_ch` takes the value of `cur_ch`, and `out_data`/`out_oe` take the result for that channel. On clocks with `slot_en` low, all three hold their values.
- R3: Connection word bit 0 = 0 and bit 1 = 0 selects constant delay. The output byte for channel c in frame F+1 is the byte received in frame F on source stream bits [5:2], source channel bits [13:6]. `out_oe` is 1.
- R4: Bit 0 = 0 and bit 1 = 1 selects low latency. If the source channel is below c, the byte comes from the current frame. Otherwise it comes from the previous frame. `out_oe` is 1.
- R5: Bit 0 = 1 and bits [2:1] = 2'b10 select message mode. `out_oe` is 1 and the byte is bits [15:8] of the word.
- R6: Bit 0 = 1 with any other value of bits [2:1] leaves the slot undriven, with `out_oe` 0 and the data byte 0. Every connection word resets to 16'h0003.
- R7: After reset, `out_oe`, `out_data`, `cur_ch` and `out_ch` are 0, and the control register reads 0.
- R8: With `host_addr` bit 10 = 0 and the low bits = 0, the host reaches the control register: bits [1:0] hold the rate code and bit 2 the bidirectional flag. A read returns the last written value. The new value takes effect at the first frame boundary after the write.
- R9: While the active bidirectional flag is 1, every byte stored from the input streams is 0.
- R10: With `host_addr` bit 10 = 1, bits [9:6] give the output stream and bits [5:0] the channel of a connection word. A write changes routing from the next slot on. `host_rdata` returns the word one clock after `host_rd`.
- R11: Any number of outputs may name the same source in the same slot, and each receives the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | One channel step this clock |
| in_data | input | 128 | Byte per input stream, stream s at [8s+7:8s] |
| cur_ch | output | 6 | Channel index of the current step |
| out_data | output | 128 | Byte per output stream |
| out_oe | output | 16 | Drive enable per output stream |
| out_ch | output | 6 | Channel that out_data belongs to |
| host_addr | input | 11 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |

## Verification
Random connection maps mix constant, low-latency, message and undriven entries. The input bytes change in every slot, so a read from the wrong bank or the wrong frame gives a byte that differs from the expected one. Idle slots are placed between steps, which shows whether the outputs hold. The rate changes and the bidirectional flag is set mid-frame, which tells a boundary-timed update apart from an immediate one. Fan-out to many outputs from one source is checked by comparing all sixteen streams in every step.

// File: rtl/tsi_core.sv
module tsi_core #(
  parameter int NSTR  = 16,
  parameter int MAXCH = 64,
  parameter int DW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_en,
  input  logic [NSTR*DW-1:0]   in_data,
  output logic [$clog2(MAXCH)-1:0] cur_ch,
  output logic [NSTR*DW-1:0]   out_data,
  output logic [NSTR-1:0]      out_oe,
  output logic [$clog2(MAXCH)-1:0] out_ch,
  input  logic [$clog2(NSTR)+$clog2(MAXCH):0] host_addr,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [15:0]          host_wdata,
  output logic [15:0]          host_rdata
);
  localparam int SW  = $clog2(NSTR);
  localparam int CHW = $clog2(MAXCH);
  localparam int AW  = 1 + SW + CHW;
  localparam int CMD = NSTR * MAXCH;
  localparam int DMD = 2 * NSTR * MAXCH;

  logic [CHW-1:0] cnt, last;
  logic           wb;
  logic [1:0]     rate_act, rate_pend;
  logic           bidir_act, bidir_pend;
  logic [15:0]    cm [CMD];
  logic [DW-1:0]  dm [DMD];
  logic [DW-1:0]  nd [NSTR];
  logic [NSTR-1:0] noe;
  logic           wrap, sel_cm;
  logic [SW+CHW-1:0] hidx;

  assign last   = CHW'((MAXCH >> (3 - int'(rate_act))) - 1);
  assign wrap   = slot_en && (cnt == last);
  assign cur_ch = cnt;
  assign sel_cm = host_addr[AW-1];
  assign hidx   = host_addr[AW-2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      wb         <= 1'b0;
      rate_act   <= 2'd0;
      bidir_act  <= 1'b0;
    end else if (slot_en) begin
      if (wrap) begin
        cnt       <= '0;
        wb        <= ~wb;
        rate_act  <= rate_pend;
        bidir_act <= bidir_pend;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (slot_en)
      for (int s = 0; s < NSTR; s++)
        dm[{wb, SW'(s), cnt}] <= bidir_act ? '0 : in_data[s*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CMD; i++) cm[i] <= 16'h0003;
    end else if (host_wr && sel_cm) begin
      cm[hidx] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_pend  <= 2'd0;
      bidir_pend <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_wr && !sel_cm && hidx == '0)
        {bidir_pend, rate_pend} <= host_wdata[2:0];
      if (host_rd)
        host_rdata <= sel_cm ? cm[hidx]
                    : (hidx == '0 ? {13'd0, bidir_pend, rate_pend} : 16'd0);
    end
  end

  always_comb begin
    for (int o = 0; o < NSTR; o++) begin
      logic [15:0]    w;
      logic [SW-1:0]  ss;
      logic [CHW-1:0] sc;
      logic           rb;
      w  = cm[{SW'(o), cnt}];
      ss = w[2 +: SW];
      sc = w[6 +: CHW];
      rb = (w[1] && sc < cnt) ? wb : ~wb;
      if (!w[0]) begin
        nd[o]  = dm[{rb, ss, sc}];
        noe[o] = 1'b1;
      end else if (w[2:1] == 2'b10) begin
        nd[o]  = w[15:8];
        noe[o] = 1'b1;
      end else begin
        nd[o]  = '0;
        noe[o] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
      out_oe   <= '0;
      out_ch   <= '0;
    end else if (slot_en) begin
      for (int o = 0; o < NSTR; o++) out_data[o*DW +: DW] <= nd[o];
      out_oe <= noe;
      out_ch <= cnt;
    end
  end

  // R1
  ch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);
  // R1
  ch_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && cnt == last) |=> cnt == '0);
  // R2
  out_ch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |=> out_ch == $past(cnt));
  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> $stable(out_data) && $stable(out_oe));
  // R8
  rate_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_en && cnt == last) |=> $stable(rate_act) && $stable(bidir_act));

  generate
    for (genvar g = 0; g < NSTR; g++) begin : g_oe
      // R6
      idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_oe[g] |-> out_data[g*DW +: DW] == '0);
    end
  endgenerate
endmodule

// File: tb/tsi_core_tb.sv
module tsi_core_tb;
  localparam int NS = 16, MC = 64, DW = 8, CHW = 6, AW = 11;
  logic clk = 0, rst_n = 0, slot_en = 0, host_wr = 0, host_rd = 0;
  logic [NS*DW-1:0] in_data = '0;
  logic [CHW-1:0] cur_ch, out_ch;
  logic [NS*DW-1:0] out_data;
  logic [NS-1:0] out_oe;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;

  tsi_core u_dut (.clk(clk), .rst_n(rst_n), .slot_en(slot_en), .in_data(in_data),
    .cur_ch(cur_ch), .out_data(out_data), .out_oe(out_oe), .out_ch(out_ch),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] mcur [NS][MC], mprev [NS][MC];
  bit vcur [NS][MC], vprev [NS][MC];
  logic [15:0] mcm [NS][MC];
  int rate_m = 0, rate_p = 0, cch = 0;
  bit bid_m = 0, bid_p = 0;
  logic [NS*DW-1:0] last_d = '0;
  logic [NS-1:0] last_oe = '0;

  function automatic int flen(int r);
    return MC >> (3 - r);
  endfunction

  // {known, oe, data}
  function automatic logic [9:0] exp_slot(int o, int c);
    logic [15:0] w = mcm[o][c];
    int s = int'(w[5:2]), sc = int'(w[13:6]);
    if (w[0]) return (w[2:1] == 2'b10) ? {2'b11, w[15:8]} : 10'b10_0000_0000;
    if (w[1] && sc < c) return {vcur[s][sc], 1'b1, mcur[s][sc]};
    return {vprev[s][sc], 1'b1, mprev[s][sc]};
  endfunction

  function automatic string tag_of(logic [15:0] w);
    if (w[0]) return (w[2:1] == 2'b10) ? "R5" : "R6";
    if (bid_m) return "R9/R11";
    return w[1] ? "R4/R11" : "R3/R11";
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [AW-1:0] a, logic [15:0] d);
    slot_en = 0; host_addr = a; host_wdata = d; host_wr = 1;
    @(posedge clk); @(negedge clk); host_wr = 0;
    if (a[AW-1]) mcm[a[9:6]][a[5:0]] = d;
    else if (a[9:0] == 0) begin rate_p = int'(d[1:0]); bid_p = d[2]; end
  endtask

  task automatic host_read(logic [AW-1:0] a, logic [15:0] exp, string tag);
    slot_en = 0; host_addr = a; host_rd = 1;
    @(posedge clk); @(negedge clk); host_rd = 0;
    check(host_rdata == exp, tag, 32'(host_rdata), 32'(exp));
  endtask

  task automatic slot(bit en);
    logic [9:0] ex [NS];
    logic [15:0] wv [NS];
    int c = cch;
    check(cur_ch == CHW'(cch), "R1", 32'(cur_ch), 32'(cch));
    slot_en = en;
    for (int s = 0; s < NS; s++) in_data[s*DW +: DW] = 8'($urandom);
    if (en) begin
      for (int o = 0; o < NS; o++) begin ex[o] = exp_slot(o, c); wv[o] = mcm[o][c]; end
      for (int s = 0; s < NS; s++) begin
        mcur[s][c] = bid_m ? 8'd0 : in_data[s*DW +: DW];
        vcur[s][c] = 1;
      end
      if (cch == flen(rate_m) - 1) begin
        for (int s = 0; s < NS; s++)
          for (int k = 0; k < MC; k++) begin
            logic [7:0] t = mprev[s][k]; bit tv = vprev[s][k];
            mprev[s][k] = mcur[s][k]; vprev[s][k] = vcur[s][k];
            mcur[s][k] = t; vcur[s][k] = tv;
          end
        rate_m = rate_p; bid_m = bid_p; cch = 0;
      end else cch++;
    end
    @(posedge clk); @(negedge clk);
    slot_en = 0;
    if (en) begin
      check(out_ch == CHW'(c), "R2", 32'(out_ch), 32'(c));
      for (int o = 0; o < NS; o++)
        if (ex[o][9])
          check({out_oe[o], out_data[o*DW +: DW]} == ex[o][8:0], tag_of(wv[o]),
                32'({out_oe[o], out_data[o*DW +: DW]}), 32'(ex[o][8:0]));
    end else begin
      check(out_data == last_d && out_oe == last_oe, "R2", 32'(out_oe), 32'(last_oe));
    end
    last_d = out_data; last_oe = out_oe;
  endtask

  task automatic prog_random(int n);
    for (int o = 0; o < NS; o++)
      for (int c = 0; c < n; c++) begin
        int k = int'($urandom % 8);
        logic [15:0] w;
        logic [7:0] src = 8'($urandom % n);
        logic [3:0] ss = 4'($urandom);
        case (k)
          0, 1, 2, 3: w = {2'b00, src[5:0], ss, 2'b00};
          4, 5:       w = {2'b00, src[5:0], ss, 2'b10};
          6:          w = {8'($urandom), 5'd0, 3'b101};
          default:    w = ($urandom % 2) ? 16'h0003 : 16'h0007;
        endcase
        host_write({1'b1, 4'(o), 6'(c)}, w);
      end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) slot(($urandom % 4) != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int o = 0; o < NS; o++)
      for (int c = 0; c < MC; c++) begin
        mcm[o][c] = 16'h0003; vcur[o][c] = 0; vprev[o][c] = 0;
        mcur[o][c] = 0; mprev[o][c] = 0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1;
    check(out_oe == 0 && out_data == 0, "R7", 32'(out_oe), 0);
    check(cur_ch == 0 && out_ch == 0, "R7", 32'({cur_ch, out_ch}), 0);
    host_read(11'h000, 16'h0000, "R7/R8");
    host_read({1'b1, 4'd9, 6'd5}, 16'h0003, "R6");

    prog_random(8);
    // directed low-latency cases on stream 0: source before, equal, after
    host_write({1'b1, 4'd0, 6'd3}, {2'b00, 6'd2, 4'd7, 2'b10});
    host_write({1'b1, 4'd0, 6'd4}, {2'b00, 6'd4, 4'd7, 2'b10});
    host_write({1'b1, 4'd0, 6'd5}, {2'b00, 6'd6, 4'd7, 2'b10});
    // fan-out: streams 1..3 channel 2 all take stream 5 channel 1
    for (int o = 1; o < 4; o++) host_write({1'b1, 4'(o), 6'd2}, {2'b00, 6'd1, 4'd5, 2'b00});
    run(64);
    host_read({1'b1, 4'd0, 6'd4}, {2'b00, 6'd4, 4'd7, 2'b10}, "R10");
    host_read({1'b1, 4'd2, 6'd2}, {2'b00, 6'd1, 4'd5, 2'b00}, "R10");
    host_write({1'b1, 4'd11, 6'd0}, 16'hA505);
    host_read({1'b1, 4'd11, 6'd0}, 16'hA505, "R10");
    run(20);

    while (cch != 3) slot(1);
    host_write(11'h000, 16'h0001);
    host_read(11'h000, 16'h0001, "R8");
    prog_random(16);
    run(90);

    while (cch != 5) slot(1);
    host_write(11'h000, 16'h0005);
    host_read(11'h000, 16'h0005, "R8/R9");
    run(70);

    host_write(11'h000, 16'h0002);
    prog_random(32);
    run(140);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule